// File: doc/BRIEF.md
# Dual-Side Doorbell Interrupt Register

This block holds a 32-bit doorbell word that two agents share. A remote agent, reached over a system bus, signals events by writing ones. Each one sets the matching bit. The local processor acknowledges events by writing ones. Each one clears the matching bit. Neither side can do the other's operation, so a bit stays set until the local side has seen it and cleared it on purpose.

Bits 30 down to 0 are general doorbells. Together they drive one level interrupt toward the local processor. Bit 31 is a machine-check flag with its own interrupt output. Both agents read the same registered word through one read port, and reading has no side effects. Bus decoding, interrupt control and masking belong to the surrounding logic. A write strobe and its data arrive on a rising clock edge, and the new register contents appear right after that edge.

Top module: `dual_doorbell`

## Requirements
- R1: After reset is asserted, all 32 register bits read 0 and both interrupt outputs are low.
- R2: A remote write (rmt_wr_i high at a rising edge) sets every bit whose data bit is 1 after that edge.
- R3: A local write (loc_wr_i high at a rising edge) clears every bit whose data bit is 1 after that edge, unless a remote write sets the same bit in that cycle.
- R4: Data bits written as 0 from either side leave their register bits unchanged. With no write strobe, the register holds its value, and reading it changes nothing.
- R5: When a remote set and a local clear target the same bit in the same cycle, the bit ends up set.
- R6: bell_irq_o is high exactly when at least one of bits 30 to 0 is set.
- R7: mchk_irq_o is high exactly when bit 31 is set. Bit 31 does not affect bell_irq_o.
- R8: rd_data_o always shows the current register value. Bit n of rd_data_o is register bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rmt_wr_i | input | 1 | Remote-side write strobe |
| rmt_wdata_i | input | 32 | Remote write data; each 1 sets the matching bit |
| loc_wr_i | input | 1 | Local-side write strobe |
| loc_wdata_i | input | 32 | Local write data; each 1 clears the matching bit |
| rd_data_o | output | 32 | Current register value, read by both sides |
| bell_irq_o | output | 1 | Level doorbell interrupt, the OR of bits 30 to 0 |
| mchk_irq_o | output | 1 | Machine-check interrupt, equal to bit 31 |

## Verification
The per-bit assertions check on every cycle that a remote set lands, including when it collides with a local clear, and that a local clear lands when no set is present. They also check that an idle bit keeps its value. At the top level, the assertions check that a doorbell or machine-check write raises the matching interrupt on the next cycle. The bench covers what no single-cycle property can show: the exact reset state, long mixed sequences of sets and clears against a reference word, and the clean split between the doorbell bits and bit 31. It also checks that clearing only bit 31, or only the doorbell bits, leaves the other interrupt alone.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned DB_WIDTH = 32;
  localparam int unsigned DB_MCHK_BIT = DB_WIDTH - 1;
  typedef logic [DB_WIDTH-1:0] db_word_t;
endpackage

// File: rtl/db_write_decode.sv
module db_write_decode #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             rmt_wr_i,
  input  logic [WIDTH-1:0] rmt_wdata_i,
  input  logic             loc_wr_i,
  input  logic [WIDTH-1:0] loc_wdata_i,
  output logic [WIDTH-1:0] set_o,
  output logic [WIDTH-1:0] clr_o
);
  always_comb begin
    set_o = rmt_wr_i ? rmt_wdata_i : '0;
    clr_o = loc_wr_i ? loc_wdata_i : '0;
  end
endmodule

// File: rtl/db_bit_cell.sv
module db_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority so a racing event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  // R5: collision resolves toward set
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> q_o);
  a_r3_clear_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/db_irq_split.sv
module db_irq_split #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             bell_o,
  output logic             mchk_o
);
  localparam int unsigned TOP = WIDTH - 1;

  assign bell_o = |bits_i[TOP-1:0];
  assign mchk_o = bits_i[TOP];
endmodule

// File: rtl/dual_doorbell.sv
module dual_doorbell
  import doorbell_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rmt_wr_i,
  input  logic [31:0] rmt_wdata_i,
  input  logic        loc_wr_i,
  input  logic [31:0] loc_wdata_i,
  output logic [31:0] rd_data_o,
  output logic        bell_irq_o,
  output logic        mchk_irq_o
);
  db_word_t set_vec, clr_vec, bits_q;

  db_write_decode #(.WIDTH(DB_WIDTH)) u_decode (
    .rmt_wr_i    (rmt_wr_i),
    .rmt_wdata_i (rmt_wdata_i),
    .loc_wr_i    (loc_wr_i),
    .loc_wdata_i (loc_wdata_i),
    .set_o       (set_vec),
    .clr_o       (clr_vec)
  );

  for (genvar i = 0; i < DB_WIDTH; i++) begin : g_cell
    db_bit_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .q_o    (bits_q[i])
    );
  end

  db_irq_split #(.WIDTH(DB_WIDTH)) u_irq (
    .bits_i (bits_q),
    .bell_o (bell_irq_o),
    .mchk_o (mchk_irq_o)
  );

  assign rd_data_o = bits_q;

  a_r6_bell_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmt_wr_i && |rmt_wdata_i[DB_MCHK_BIT-1:0]) |=> bell_irq_o);
  a_r7_mchk_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmt_wr_i && rmt_wdata_i[DB_MCHK_BIT]) |=> mchk_irq_o);
  a_r7_mchk_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_wr_i && loc_wdata_i[DB_MCHK_BIT] && !(rmt_wr_i && rmt_wdata_i[DB_MCHK_BIT]))
      |=> !mchk_irq_o);
endmodule

// File: tb/dual_doorbell_bench.sv
`timescale 1ns/1ps
module dual_doorbell_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rmt_wr = 1'b0;
  logic [31:0] rmt_wd = '0;
  logic        loc_wr = 1'b0;
  logic [31:0] loc_wd = '0;
  logic [31:0] rd;
  logic        bell, mchk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_doorbell u_dual_doorbell (
    .clk_i(clk), .rst_ni(rst_n),
    .rmt_wr_i(rmt_wr), .rmt_wdata_i(rmt_wd),
    .loc_wr_i(loc_wr), .loc_wdata_i(loc_wd),
    .rd_data_o(rd), .bell_irq_o(bell), .mchk_irq_o(mchk)
  );

  function automatic logic [31:0] next_val(logic [31:0] cur, logic rw, logic [31:0] rwd,
                                           logic lw, logic [31:0] lwd);
    logic [31:0] s = rw ? rwd : 32'h0;
    logic [31:0] c = lw ? lwd : 32'h0;
    return (cur & ~c) | s;
  endfunction

  function automatic logic exp_bell(logic [31:0] v);
    return |v[30:0];
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp(req, rd, model);
    cmp("R6", {31'b0, bell}, {31'b0, exp_bell(model)});
    cmp("R7", {31'b0, mchk}, {31'b0, model[31]});
  endtask

  // drive at negedge, apply one edge, sample at next negedge
  task automatic cyc(logic rw, logic [31:0] rwd, logic lw, logic [31:0] lwd);
    rmt_wr = rw; rmt_wd = rwd; loc_wr = lw; loc_wd = lwd;
    model = next_val(model, rw, rwd, lw, lwd);
    @(negedge clk);
    rmt_wr = 1'b0; loc_wr = 1'b0; rmt_wd = '0; loc_wd = '0;
  endtask

  initial begin
    int unsigned seed = 32'h1d0b_e115;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    cyc(1, 32'h0000_00a5, 0, '0); check_all("R2");
    cyc(1, 32'h0, 1, 32'h0);      check_all("R4");
    cyc(0, 32'hffff_ffff, 0, 32'hffff_ffff); check_all("R4");
    @(negedge clk); check_all("R8");
    cyc(0, '0, 1, 32'h0000_0005); check_all("R3");
    cyc(1, 32'h8000_0000, 0, '0); check_all("R7");
    cyc(0, '0, 1, 32'h0000_00a0); check_all("R6");
    cyc(0, '0, 1, 32'h8000_0000); check_all("R7");
    cyc(1, 32'h0000_0f00, 1, 32'h0000_0300); check_all("R5");
    cyc(1, 32'hffff_ffff, 0, '0); check_all("R2");
    cyc(0, '0, 1, 32'h7fff_ffff); check_all("R6");
    cyc(1, 32'h8000_0001, 1, 32'hffff_ffff); check_all("R5");
    cyc(0, '0, 1, 32'hffff_ffff); check_all("R3");

    for (int i = 0; i < 600; i++) begin
      logic rw = 1'($urandom);
      logic lw = 1'($urandom);
      logic [31:0] a = $urandom & $urandom;
      logic [31:0] b = $urandom;
      cyc(rw, a, lw, b);
      check_all(rw && lw ? "R5" : (rw ? "R2" : (lw ? "R3" : "R4")));
    end

    rst_n = 1'b0;
    model = '0;
    #1;
    check_all("R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule